// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Shadowed Settings

This block produces one pulse-width-modulated output from a single 32-bit control word. Each clock the active frequency increment is added to an N-bit phase accumulator that wraps modulo 2^N. The output frequency is therefore clock times increment over 2^N, which gives a fractional frequency setting rather than an integer period count. The duty cycle comes from comparing the top eight accumulator bits against an 8-bit on-time divisor. The divisor is inverted: a larger value gives a shorter high time.

Software writes land in shadow fields. They reach the running logic only through an update request, which is applied at the next accumulator wrap while the output runs, or at once while it is stopped. A control state machine tracks this with four named states. COLD means no update has happened since reset. STOPPED means settings have been loaded and the output is disabled. RUNNING means the output is active with nothing pending. PENDING means the output is active and an update waits for the wrap. The transitions are:

- COLD to STOPPED or RUNNING on the first update.
- STOPPED to RUNNING on enable.
- RUNNING to PENDING on an update request.
- PENDING to RUNNING on wrap, when the copy is made.
- RUNNING or PENDING to STOPPED on disable.

Top module: `phase_pwm`

## Requirements
- R1: After reset the read word is zero, the output is low and the accumulator is zero.
- R2: Read layout: bit 31 is the enable, bit 30 reads 1 while an update is pending, bits 8 to 8+N-1 are the shadow increment, bits 7:0 are the shadow divisor, and all other bits read 0.
- R3: A write changes only the bits of the byte lanes whose strobe is set. A write strobing only lane 3 (enable and update bits, default N=16) leaves the shadow increment and divisor unchanged.
- R4: While the enable bit is clear, the output is low from the next cycle on.
- R5: If no update has been requested since reset, setting the enable bit does not start the output.
- R6: Writing new shadow fields while running does not change the output until an update is requested.
- R7: A write with bit 30 set (lane 3 strobed) marks an update pending. While the output is not running, the copy happens on the following cycle and the pending bit then reads 0.
- R8: While running, a pending update is applied only at the next accumulator wrap. The pending bit stays 1 until then.
- R9: The output is high exactly while the top 8 accumulator bits are at least the active divisor. For an increment of 2^k (k ≤ 8, N=16), one period holds (256 − divisor)·256/increment high cycles.
- R10: The output period is 2^N / increment cycles, so a window of two periods holds exactly two rising edges (divisor 1..255).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_strb | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data (shadow fields, enable, pending flag) |
| pwm_out | output | 1 | PWM output |

## Verification
Random divisors with power-of-two increments are used to measure high-cycle counts and rising edges over whole periods. These runs separate a correct comparison direction and period length from an off-by-one in the compare or an accumulator that does not wrap. Directed sequences cover several cases: enabling without a prior update, rewriting the shadow fields while running, and an update issued well before a known wrap. These separate immediate application from deferred application and show whether shadow writes leak into the running output. Lane-3-only writes and disable writes show whether the control bits can disturb the stored fields.

// File: rtl/pwm_pa_pkg.sv
package pwm_pa_pkg;
    typedef enum logic [1:0] {
        ST_COLD     = 2'd0,
        ST_STOPPED  = 2'd1,
        ST_RUNNING  = 2'd2,
        ST_PENDING  = 2'd3
    } pa_state_e;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int DIV_W   = 8;
    localparam int EN_BIT  = 31;
    localparam int UPD_BIT = 30;
    localparam int INC_LSB = 8;
endpackage

// File: rtl/pwm_pa_regs.sv
module pwm_pa_regs
    import pwm_pa_pkg::*;
#(
    parameter int INC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [LANES-1:0]     wr_strb,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 upd_done,
    output logic [INC_W-1:0]     sh_inc,
    output logic [DIV_W-1:0]     sh_div,
    output logic                 en,
    output logic                 upd_pend,
    output logic [WORD_W-1:0]    rd_data
);
    logic [WORD_W-1:0] merged;
    logic              unused_merge;

    always_comb begin
        rd_data                     = '0;
        rd_data[EN_BIT]             = en;
        rd_data[UPD_BIT]            = upd_pend;
        rd_data[INC_LSB +: INC_W]   = sh_inc;
        rd_data[DIV_W-1:0]          = sh_div;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = wr_strb[g] ? wr_data[8*g +: 8] : rd_data[8*g +: 8];
    end

    assign unused_merge = ^merged;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_inc   <= '0;
            sh_div   <= '0;
            en       <= 1'b0;
            upd_pend <= 1'b0;
        end else begin
            if (wr_en) begin
                sh_inc <= merged[INC_LSB +: INC_W];
                sh_div <= merged[DIV_W-1:0];
                if (wr_strb[LANES-1]) en <= merged[EN_BIT];
            end
            if (wr_en && wr_strb[LANES-1] && wr_data[UPD_BIT]) upd_pend <= 1'b1;
            else if (upd_done)                                 upd_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_pa_ctrl.sv
module pwm_pa_ctrl
    import pwm_pa_pkg::*;
#(
    parameter int INC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              upd_pend,
    input  logic              wrap,
    input  logic [INC_W-1:0]  sh_inc,
    input  logic [DIV_W-1:0]  sh_div,
    output logic [INC_W-1:0]  act_inc,
    output logic [DIV_W-1:0]  act_div,
    output logic              run,
    output logic              upd_done
);
    pa_state_e state_q, state_d;
    logic      copy;

    always_comb begin
        state_d = state_q;
        copy    = 1'b0;
        unique case (state_q)
            ST_COLD: begin
                if (upd_pend) begin
                    copy    = 1'b1;
                    state_d = en ? ST_RUNNING : ST_STOPPED;
                end
            end
            ST_STOPPED: begin
                if (upd_pend) copy = 1'b1;
                if (en)       state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                if (!en)          state_d = ST_STOPPED;
                else if (upd_pend) state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (!en) state_d = ST_STOPPED;
                else if (wrap) begin
                    copy    = 1'b1;
                    state_d = ST_RUNNING;
                end
            end
            default: state_d = ST_COLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_inc <= '0;
            act_div <= '0;
        end else if (copy) begin
            act_inc <= sh_inc;
            act_div <= sh_div;
        end
    end

    assign run      = (state_q == ST_RUNNING) || (state_q == ST_PENDING);
    assign upd_done = copy;

    // R6: active settings move only when an update is pending
    assert_active_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pend |=> ($stable(act_inc) && $stable(act_div)));
endmodule

// File: rtl/pwm_pa_core.sv
module pwm_pa_core
    import pwm_pa_pkg::*;
#(
    parameter int INC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [INC_W-1:0]  act_inc,
    input  logic [DIV_W-1:0]  act_div,
    output logic              wrap,
    output logic              pwm_out
);
    localparam int TOP_LSB = INC_W - DIV_W;

    logic [INC_W-1:0] acc;
    logic [INC_W:0]   sum;

    assign sum  = {1'b0, acc} + {1'b0, act_inc};
    assign wrap = run && sum[INC_W];

    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (run) acc <= sum[INC_W-1:0];
        else          acc <= '0;
    end

    assign pwm_out = run && (acc[INC_W-1:TOP_LSB] >= act_div);

    // R1: the accumulator rests at zero while the output is not running
    assert_acc_rest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (acc == '0) || $past(run));
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
    import pwm_pa_pkg::*;
#(
    parameter int INC_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_strb,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    logic [INC_W-1:0] sh_inc, act_inc;
    logic [DIV_W-1:0] sh_div, act_div;
    logic             en, upd_pend, upd_done, run, wrap;

    pwm_pa_regs #(.INC_W(INC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb),
        .wr_data(wr_data), .upd_done(upd_done), .sh_inc(sh_inc),
        .sh_div(sh_div), .en(en), .upd_pend(upd_pend), .rd_data(rd_data)
    );

    pwm_pa_ctrl #(.INC_W(INC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .upd_pend(upd_pend), .wrap(wrap),
        .sh_inc(sh_inc), .sh_div(sh_div), .act_inc(act_inc),
        .act_div(act_div), .run(run), .upd_done(upd_done)
    );

    pwm_pa_core #(.INC_W(INC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .act_inc(act_inc),
        .act_div(act_div), .wrap(wrap), .pwm_out(pwm_out)
    );

    // R4: a cleared enable silences the output on the next cycle
    assert_disabled_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);

    // R7: while stopped, a pending update is consumed on the next edge
    assert_stopped_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pend && !run && !(wr_en && wr_strb[3] && wr_data[UPD_BIT])) |=> !upd_pend);

    // R8: while running, a pending update survives until the wrap
    assert_wait_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pend && run && en && !wrap) |=> upd_pend);
endmodule

// File: tb/test_phase_pwm.sv
`timescale 1ns/1ps
module test_phase_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    phase_pwm #(.INC_W(16)) i_phase_pwm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    function automatic int exp_high(input int dv, input int inc);
        return (256 - dv) * (256 / inc);
    endfunction

    function automatic logic [31:0] fields(input int inc, input int dv);
        return (32'(inc) << 8) | 32'(dv);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_strb = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) cnt++;
        end
    endtask

    task automatic count_rise(input int n, output int cnt);
        logic prev;
        prev = pwm_out;
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) cnt++;
            prev = pwm_out;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R1 read word after reset", rd_data, 32'h0);
        chk("R1 output after reset", 32'(pwm_out), 32'h0);

        wr(4'b0111, fields(64, 192));
        chk("R2 field readback", rd_data, fields(64, 192));

        wr(4'b1000, 32'h8000_0000);
        chk("R3 lane3 write keeps fields", rd_data, 32'h8000_0000 | fields(64, 192));
        count_high(600, c);
        chk("R5 enable without prior update stays low", 32'(c), 32'h0);

        @(negedge clk);
        wr_en = 1'b1; wr_strb = 4'b1000; wr_data = 32'hC000_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0; wr_data = '0;
        chk("R7 pending bit set", 32'(rd_data[30]), 32'h1);
        idle(3);
        chk("R7 pending cleared when not running", 32'(rd_data[30]), 32'h0);
        idle(8);
        count_high(1024, c);
        chk("R9 high count inc64 div192", 32'(c), 32'(exp_high(192, 64)));
        count_rise(2048, c);
        chk("R10 two rises in two periods", 32'(c), 32'h2);

        wr(4'b0001, 32'h0000_0020);
        chk("R3 lane0 write keeps increment", rd_data, 32'h8000_0000 | fields(64, 32));
        idle(4);
        count_high(1024, c);
        chk("R6 shadow write not applied", 32'(c), 32'(exp_high(192, 64)));

        @(negedge clk);
        wr_en = 1'b1; wr_strb = 4'b1000; wr_data = 32'hC000_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0; wr_data = '0;
        chk("R8 pending while running", 32'(rd_data[30]), 32'h1);
        idle(1100);
        chk("R8 pending cleared after wrap", 32'(rd_data[30]), 32'h0);
        count_high(1024, c);
        chk("R9 high count inc64 div32", 32'(c), 32'(exp_high(32, 64)));

        for (int t = 0; t < 6; t++) begin
            int k, dv, inc, per;
            k   = $urandom_range(8, 5);
            dv  = $urandom_range(255, 1);
            inc = 1 << k;
            per = 65536 / inc;
            wr(4'b0111, fields(inc, dv));
            wr(4'b1000, 32'hC000_0000);
            idle(2200);
            count_high(per, c);
            chk("R9 random high count", 32'(c), 32'(exp_high(dv, inc)));
            count_rise(2 * per, c);
            chk("R10 random rising edges", 32'(c), 32'h2);
        end

        wr(4'b1000, 32'h0000_0000);
        idle(4);
        wr(4'b0011, fields(4, 128));
        wr(4'b1000, 32'h4000_0000);
        idle(3);
        chk("R7 immediate copy while stopped", 32'(rd_data[30]), 32'h0);
        wr(4'b1000, 32'h8000_0000);
        idle(200);
        wr(4'b0001, 32'h0000_0040);
        wr(4'b1000, 32'hC000_0000);
        idle(1000);
        chk("R8 no copy before wrap", 32'(rd_data[30]), 32'h1);
        idle(16384);
        chk("R8 copy at wrap", 32'(rd_data[30]), 32'h0);
        count_high(16384, c);
        chk("R8 new divisor after wrap", 32'(c), 32'(exp_high(64, 4)));

        wr(4'b1000, 32'h0000_0000);
        count_high(500, c);
        chk("R4 disabled output low", 32'(c), 32'h0);
        chk("R3 disable keeps fields", rd_data, fields(4, 64));

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule